// File: doc/BRIEF.md
# Receive Frame Queue Filer

The filer decides where each received frame goes. Software programs a table of rules, one slot per index. It first sets an index register and then writes a rule word and a reference value into that slot. The index register also selects which slot the read-back port shows while the engine is idle. Upstream logic has already reduced the frame to sixteen property values. It presents them with a one-cycle valid pulse. The engine then walks the table from slot 0 upward, one slot per clock, until a rule decides the frame or the table runs out.

A deciding rule either rejects the frame or accepts it. An accepted frame gets a 6-bit queue number for its control block and a ring number. The ring is the queue number folded modulo 8, or ring 0 when the single-ring mode input is high. The deciding rule may also raise an interrupt event. That event is mirrored onto a timer-domain event when the timer enable input is high. Rules can be chained so that several conditions must all hold before a decision is taken.

The result fields are registered and held until the next result. The event flags and the done strobe are one-cycle pulses.

Top module: `frame_filer`

## Requirements
- R1: After reset, all result outputs, both event flags and the busy flag are 0.
- R2: A rule word reads back unchanged in bits 15..0 and as zero in bits 31..16. The bit fields are: queue Q in bits 5..0, interrupt flag in bit 6, an unused cluster bit in bit 7, reject in bit 8, chain in bit 9, compare code in bits 11..10, property select in bits 15..12.
- R3: A rule tests property[select] (bits select*16 upward on the property input) against its reference value, unsigned. The compare codes are: 0 equal, 1 not equal, 2 property greater or equal, 3 property less than.
- R4: Slots are examined in ascending order. The lowest slot whose test holds and whose chain bit is 0 decides the frame.
- R5: A frame taken at clock edge E and decided at slot k produces its done pulse after edge E+k+2. A frame that no slot decides produces its done pulse after edge E+257.
- R6: A deciding slot with reject set reports reject=1, queue 0, ring 0 and no event.
- R7: An accepted frame reports Q. Its ring is Q modulo 8 with single-ring mode low, and 0 with single-ring mode high.
- R8: An accepted frame whose deciding slot has the interrupt bit set pulses the filer event with done. It also pulses the timer event when timer enable is high.
- R9: A slot with chain set never decides on its own. If its test fails, every following slot up to and including the next slot with chain clear is skipped.
- R10: A frame that no slot decides is accepted to queue 0, ring 0, with no event.
- R11: While a scan runs, busy is high. Rule and value writes are dropped, and a new frame valid is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_addr_we | input | 1 | Load the table index register |
| cfg_addr_wdata | input | 8 | New table index |
| cfg_ctl_we | input | 1 | Write rule word into the indexed slot |
| cfg_ctl_wdata | input | 32 | Rule word (bits 31..16 discarded) |
| cfg_val_we | input | 1 | Write reference value into the indexed slot |
| cfg_val_wdata | input | 16 | Reference value |
| cfg_ctl_rdata | output | 32 | Rule word of the indexed slot, valid while idle |
| cfg_busy | output | 1 | Scan in progress |
| mode_single_ring | input | 1 | Send all accepted frames to ring 0 |
| timer_en | input | 1 | Mirror interrupt events to the timer event |
| frm_valid | input | 1 | Frame properties present |
| frm_props | input | 256 | Sixteen 16-bit property values |
| res_done | output | 1 | Result strobe |
| res_reject | output | 1 | Frame rejected |
| res_queue | output | 6 | Queue number for the frame control block |
| res_ring | output | 3 | Ring number |
| res_evt_filer | output | 1 | Filer interrupt event pulse |
| res_evt_timer | output | 1 | Timer-domain receive event pulse |

## Verification
A wrong skip flag or a misdecoded compare code shows at the outputs as a different queue number, or as a done strobe at the wrong cycle. The done cycle is fixed by the slot that decides, so each vector checks the latency exactly as well as the fields. A scan counter that stops early or runs on moves the default-result strobe away from edge 257. Writes that leak through while busy show up when the rule is read back afterwards, and again on the next frame that uses that rule.

// File: rtl/filer_pkg.sv
package filer_pkg;
  localparam int CTL_W  = 16;
  localparam int CFG_W  = 32;
  localparam int NPROP  = 16;
  localparam int PID_W  = 4;
  localparam int Q_W    = 6;
  localparam int RING_W = 3;

  typedef enum logic [1:0] {
    CMP_EQ = 2'd0,
    CMP_NE = 2'd1,
    CMP_GE = 2'd2,
    CMP_LT = 2'd3
  } cmp_e;

  typedef struct packed {
    logic [PID_W-1:0] pid;
    cmp_e             cmp;
    logic             chain;
    logic             rej;
    logic             cle;
    logic             gpi;
    logic [Q_W-1:0]   q;
  } rule_t;
endpackage

// File: rtl/filer_rule_mem.sv
module filer_rule_mem #(
  parameter int DEPTH = 256,
  parameter int DW    = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/filer_cmp.sv
module filer_cmp
  import filer_pkg::*;
#(
  parameter int PROP_W = 16
) (
  input  logic [NPROP*PROP_W-1:0] props,
  input  logic [PID_W-1:0]        pid,
  input  cmp_e                    cmp,
  input  logic [PROP_W-1:0]       ref_val,
  output logic                    hit
);
  logic [PROP_W-1:0] lane [NPROP];
  logic [PROP_W-1:0] sel;

  for (genvar g = 0; g < NPROP; g++) begin : g_lane
    assign lane[g] = props[g*PROP_W +: PROP_W];
  end

  assign sel = lane[pid];

  always_comb begin
    unique case (cmp)
      CMP_EQ:  hit = (sel == ref_val);
      CMP_NE:  hit = (sel != ref_val);
      CMP_GE:  hit = (sel >= ref_val);
      default: hit = (sel <  ref_val);
    endcase
  end
endmodule

// File: rtl/filer_seq.sv
module filer_seq
  import filer_pkg::*;
#(
  parameter int ENTRIES = 256,
  localparam int AW     = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frm_valid,
  input  logic              ent_chain,
  input  logic              ent_rej,
  input  logic              ent_gpi,
  input  logic [Q_W-1:0]    ent_q,
  input  logic              ent_hit,
  input  logic              single_ring,
  input  logic              timer_en,
  output logic              start,
  output logic              busy,
  output logic              issuing,
  output logic [AW-1:0]     scan_idx,
  output logic              res_done,
  output logic              res_reject,
  output logic [Q_W-1:0]    res_queue,
  output logic [RING_W-1:0] res_ring,
  output logic              res_evt_filer,
  output logic              res_evt_timer
);
  localparam logic [AW-1:0] LAST = AW'(ENTRIES - 1);

  logic          rd_vld;
  logic [AW-1:0] rd_idx;
  logic          skip;
  logic          decide, exhausted, finish, accept;

  always_comb begin
    start     = frm_valid && !busy;
    decide    = rd_vld && !skip && !ent_chain && ent_hit;
    exhausted = rd_vld && (rd_idx == LAST) && !decide;
    finish    = decide || exhausted;
    accept    = decide && !ent_rej;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy          <= 1'b0;
      issuing       <= 1'b0;
      scan_idx      <= '0;
      rd_vld        <= 1'b0;
      rd_idx        <= '0;
      skip          <= 1'b0;
      res_done      <= 1'b0;
      res_reject    <= 1'b0;
      res_queue     <= '0;
      res_ring      <= '0;
      res_evt_filer <= 1'b0;
      res_evt_timer <= 1'b0;
    end else begin
      res_done      <= 1'b0;
      res_evt_filer <= 1'b0;
      res_evt_timer <= 1'b0;
      if (start) begin
        busy     <= 1'b1;
        issuing  <= 1'b1;
        scan_idx <= '0;
        rd_vld   <= 1'b0;
        skip     <= 1'b0;
      end else if (busy) begin
        rd_vld <= issuing && !finish;
        rd_idx <= scan_idx;
        if (issuing) begin
          if (scan_idx == LAST) issuing  <= 1'b0;
          else                  scan_idx <= scan_idx + 1'b1;
        end
        if (rd_vld) begin
          if (skip) begin
            if (!ent_chain) skip <= 1'b0;
          end else if (ent_chain && !ent_hit) begin
            skip <= 1'b1;
          end
        end
        if (finish) begin
          busy          <= 1'b0;
          issuing       <= 1'b0;
          rd_vld        <= 1'b0;
          res_done      <= 1'b1;
          res_reject    <= decide && ent_rej;
          res_queue     <= accept ? ent_q : '0;
          res_ring      <= (accept && !single_ring) ? ent_q[RING_W-1:0] : '0;
          res_evt_filer <= accept && ent_gpi;
          res_evt_timer <= accept && ent_gpi && timer_en;
        end
      end else begin
        rd_vld <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/frame_filer.sv
module frame_filer
  import filer_pkg::*;
#(
  parameter int ENTRIES = 256,
  parameter int PROP_W  = 16,
  localparam int AW     = $clog2(ENTRIES)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    cfg_addr_we,
  input  logic [AW-1:0]           cfg_addr_wdata,
  input  logic                    cfg_ctl_we,
  input  logic [CFG_W-1:0]        cfg_ctl_wdata,
  input  logic                    cfg_val_we,
  input  logic [PROP_W-1:0]       cfg_val_wdata,
  output logic [CFG_W-1:0]        cfg_ctl_rdata,
  output logic                    cfg_busy,
  input  logic                    mode_single_ring,
  input  logic                    timer_en,
  input  logic                    frm_valid,
  input  logic [NPROP*PROP_W-1:0] frm_props,
  output logic                    res_done,
  output logic                    res_reject,
  output logic [Q_W-1:0]          res_queue,
  output logic [RING_W-1:0]       res_ring,
  output logic                    res_evt_filer,
  output logic                    res_evt_timer
);
  logic [AW-1:0]           addr_q;
  logic [AW-1:0]           scan_idx;
  logic [AW-1:0]           raddr;
  logic                    issuing, start, busy;
  logic [CTL_W-1:0]        ctl_rd;
  logic [PROP_W-1:0]       val_rd;
  logic [NPROP*PROP_W-1:0] props_q;
  rule_t                   cur;
  logic                    hit;
  logic                    unused_bits;

  assign unused_bits = ^{cfg_ctl_wdata[CFG_W-1:CTL_W], cur.cle};

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q  <= '0;
      props_q <= '0;
    end else begin
      if (cfg_addr_we) addr_q  <= cfg_addr_wdata;
      if (start)       props_q <= frm_props;
    end
  end

  assign raddr = issuing ? scan_idx : addr_q;

  filer_rule_mem #(.DEPTH(ENTRIES), .DW(CTL_W)) u_ctl_mem (
    .clk   (clk),
    .we    (cfg_ctl_we && !busy),
    .waddr (addr_q),
    .wdata (cfg_ctl_wdata[CTL_W-1:0]),
    .raddr (raddr),
    .rdata (ctl_rd)
  );

  filer_rule_mem #(.DEPTH(ENTRIES), .DW(PROP_W)) u_val_mem (
    .clk   (clk),
    .we    (cfg_val_we && !busy),
    .waddr (addr_q),
    .wdata (cfg_val_wdata),
    .raddr (raddr),
    .rdata (val_rd)
  );

  assign cur = rule_t'(ctl_rd);
  assign cfg_ctl_rdata = {{(CFG_W-CTL_W){1'b0}}, ctl_rd};

  filer_cmp #(.PROP_W(PROP_W)) u_cmp (
    .props   (props_q),
    .pid     (cur.pid),
    .cmp     (cur.cmp),
    .ref_val (val_rd),
    .hit     (hit)
  );

  filer_seq #(.ENTRIES(ENTRIES)) u_seq (
    .clk           (clk),
    .rst           (rst),
    .frm_valid     (frm_valid),
    .ent_chain     (cur.chain),
    .ent_rej       (cur.rej),
    .ent_gpi       (cur.gpi),
    .ent_q         (cur.q),
    .ent_hit       (hit),
    .single_ring   (mode_single_ring),
    .timer_en      (timer_en),
    .start         (start),
    .busy          (busy),
    .issuing       (issuing),
    .scan_idx      (scan_idx),
    .res_done      (res_done),
    .res_reject    (res_reject),
    .res_queue     (res_queue),
    .res_ring      (res_ring),
    .res_evt_filer (res_evt_filer),
    .res_evt_timer (res_evt_timer)
  );

  assign cfg_busy = busy;
endmodule

// File: rtl/filer_chk.sv
module filer_chk
  import filer_pkg::*;
#(
  parameter int ENTRIES = 256
) (
  input logic              clk,
  input logic              rst,
  input logic              cfg_busy,
  input logic              frm_valid,
  input logic              mode_single_ring,
  input logic              timer_en,
  input logic              res_done,
  input logic              res_reject,
  input logic [Q_W-1:0]    res_queue,
  input logic [RING_W-1:0] res_ring,
  input logic              res_evt_filer,
  input logic              res_evt_timer
);
  localparam int CW = $clog2(ENTRIES + 3) + 1;
  logic [CW-1:0] busy_cnt;

  always_ff @(posedge clk) begin
    if (rst)           busy_cnt <= '0;
    else if (cfg_busy) busy_cnt <= busy_cnt + 1'b1;
    else               busy_cnt <= '0;
  end

  // R5
  done_ends_scan_chk: assert property (@(posedge clk) disable iff (rst)
    res_done |-> (!cfg_busy && $past(cfg_busy)));

  // R5
  scan_bound_chk: assert property (@(posedge clk) disable iff (rst)
    int'(busy_cnt) <= ENTRIES + 1);

  // R6
  reject_clean_chk: assert property (@(posedge clk) disable iff (rst)
    (res_done && res_reject) |-> (res_queue == '0 && res_ring == '0 &&
                                  !res_evt_filer && !res_evt_timer));

  // R7
  single_ring_chk: assert property (@(posedge clk) disable iff (rst)
    (res_done && $past(mode_single_ring)) |-> (res_ring == '0));

  // R7
  ring_fold_chk: assert property (@(posedge clk) disable iff (rst)
    (res_done && !res_reject && !$past(mode_single_ring)) |->
      (res_ring == res_queue[RING_W-1:0]));

  // R8
  timer_evt_chk: assert property (@(posedge clk) disable iff (rst)
    res_evt_timer |-> (res_evt_filer && $past(timer_en)));

  // R8
  evt_with_done_chk: assert property (@(posedge clk) disable iff (rst)
    res_evt_filer |-> (res_done && !res_reject));

  // R11
  scan_start_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(cfg_busy) |-> $past(frm_valid));
endmodule

bind frame_filer filer_chk #(.ENTRIES(ENTRIES)) u_filer_chk (
  .clk              (clk),
  .rst              (rst),
  .cfg_busy         (cfg_busy),
  .frm_valid        (frm_valid),
  .mode_single_ring (mode_single_ring),
  .timer_en         (timer_en),
  .res_done         (res_done),
  .res_reject       (res_reject),
  .res_queue        (res_queue),
  .res_ring         (res_ring),
  .res_evt_filer    (res_evt_filer),
  .res_evt_timer    (res_evt_timer)
);

// File: tb/tb_frame_filer.sv
`timescale 1ns/1ps
module tb_frame_filer;
  localparam int ENTRIES = 256;
  localparam int PROP_W  = 16;
  localparam int AW      = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cfg_addr_we = 1'b0;
  logic [AW-1:0] cfg_addr_wdata = '0;
  logic          cfg_ctl_we = 1'b0;
  logic [31:0]   cfg_ctl_wdata = '0;
  logic          cfg_val_we = 1'b0;
  logic [15:0]   cfg_val_wdata = '0;
  logic [31:0]   cfg_ctl_rdata;
  logic          cfg_busy;
  logic          mode_single_ring = 1'b0;
  logic          timer_en = 1'b0;
  logic          frm_valid = 1'b0;
  logic [255:0]  frm_props = '0;
  logic          res_done, res_reject, res_evt_filer, res_evt_timer;
  logic [5:0]    res_queue;
  logic [2:0]    res_ring;

  int passes = 0;
  int fails  = 0;
  int cyc    = 0;
  int n_done = 0;

  always #2.5 clk = ~clk;

  frame_filer #(.ENTRIES(ENTRIES), .PROP_W(PROP_W)) dut (.*);

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (!rst && res_done) n_done <= n_done + 1;
    if (cyc == 150000) begin
      fails = fails + 1;
      $display("FAIL watchdog: actual %0d expected <150000 cycles", cyc);
      $display("%0d/%0d checks passed", passes, passes + fails);
      $finish;
    end
  end

  function automatic logic [31:0] rw(int pid, int cmp, int chain, int rej, int gpi, int q);
    return {16'h0, 4'(pid), 2'(cmp), 1'(chain), 1'(rej), 1'b0, 1'(gpi), 6'(q)};
  endfunction

  function automatic logic [63:0] mkv(int p0, int p1, int s, int t, int rej,
                                      int q, int ring, int ef, int et, int k);
    return {9'h0, 9'(k), 1'(et), 1'(ef), 3'(ring), 6'(q), 1'(rej), 1'(t), 1'(s),
            16'(p1), 16'(p0)};
  endfunction

  localparam logic [63:0] VEC [12] = '{
    mkv('h0100, 'h0000, 0, 0, 0,  5, 5, 1, 0,   0), // R3 equal at slot 0
    mkv('h0100, 'h0000, 1, 1, 0,  5, 0, 1, 1,   0), // R7 single ring, R8 timer
    mkv('h0250, 'h0001, 0, 0, 0, 42, 2, 0, 0,   2), // R9 two-link chain, R3 ne/ge
    mkv('h0250, 'h0001, 1, 0, 0, 42, 0, 0, 0,   2), // R7 single ring
    mkv('h0300, 'h0000, 0, 1, 1,  0, 0, 0, 0,   3), // R6 reject after R9 skip
    mkv('h0300, 'h0005, 0, 0, 0, 42, 2, 0, 0,   2), // R4 lower slot wins
    mkv('h0010, 'h0077, 0, 1, 0, 63, 7, 1, 1,   6), // R9 three-link chain, R3 lt
    mkv('h0010, 'h0012, 0, 0, 0,  9, 1, 0, 0,   7), // R9 broken chain skipped
    mkv('h0055, 'h0077, 0, 0, 0,  9, 1, 0, 0,   7), // R9 last link fails
    mkv('h0070, 'h9000, 0, 1, 0, 33, 1, 1, 1, 200), // R5 deep slot
    mkv('h0070, 'h0005, 0, 0, 0,  0, 0, 0, 0, 255), // R10 no decision
    mkv('h0101, 'h0000, 1, 1, 0,  0, 0, 0, 0, 255)  // R10 no decision
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    if (ok) passes++;
    else begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic set_addr(input int idx);
    cfg_addr_we = 1'b1; cfg_addr_wdata = AW'(idx);
    @(negedge clk);
    cfg_addr_we = 1'b0;
  endtask

  task automatic put_entry(input int idx, input logic [31:0] c, input int v);
    set_addr(idx);
    cfg_ctl_we = 1'b1; cfg_ctl_wdata = c;
    cfg_val_we = 1'b1; cfg_val_wdata = 16'(v);
    @(negedge clk);
    cfg_ctl_we = 1'b0; cfg_val_we = 1'b0;
  endtask

  task automatic read_ctl(input int idx, output logic [31:0] d);
    set_addr(idx);
    @(negedge clk);
    d = cfg_ctl_rdata;
  endtask

  task automatic drive_frame(input int p0, input int p1);
    frm_props = '0;
    frm_props[15:0]  = 16'(p0);
    frm_props[31:16] = 16'(p1);
    frm_valid = 1'b1;
    @(negedge clk);
    frm_valid = 1'b0;
  endtask

  task automatic wait_done(output int lat);
    lat = 1;
    while (!res_done && lat < 600) begin
      @(negedge clk);
      lat++;
    end
  endtask

  initial begin
    logic [31:0] rd;
    int lat;
    int base;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    check(res_done == 0 && res_reject == 0 && res_evt_filer == 0 && res_evt_timer == 0,
          "R1", {res_done, res_reject, res_evt_filer, res_evt_timer}, 0);
    check(res_queue == 0 && res_ring == 0, "R1", {res_queue, res_ring}, 0);
    check(cfg_busy == 0, "R1", cfg_busy, 0);

    for (int i = 0; i < ENTRIES; i++) put_entry(i, rw(0, 3, 0, 0, 0, 0), 0);

    // R2 field layout and reserved bits
    put_entry(100, 32'hABCD_5A7B, 'h1234);
    read_ctl(100, rd);
    check(rd == 32'h0000_5A7B, "R2", rd, 32'h0000_5A7B);
    put_entry(100, rw(0, 3, 0, 0, 0, 0), 0);
    put_entry(0, rw(0, 0, 0, 0, 1, 5), 'h0100);
    read_ctl(0, rd);
    check(rd == 32'h0000_0045, "R2", rd, 32'h0000_0045);

    put_entry(1,   rw(1, 1, 1, 0, 0,  0), 'h0000);
    put_entry(2,   rw(0, 2, 0, 0, 0, 42), 'h0200);
    put_entry(3,   rw(0, 0, 0, 1, 0,  0), 'h0300);
    put_entry(4,   rw(1, 0, 1, 0, 0,  0), 'h0077);
    put_entry(5,   rw(1, 0, 1, 0, 0,  0), 'h0077);
    put_entry(6,   rw(0, 3, 0, 0, 1, 63), 'h0050);
    put_entry(7,   rw(0, 3, 0, 0, 0,  9), 'h0060);
    put_entry(200, rw(1, 2, 0, 0, 1, 33), 'h8000);

    for (int v = 0; v < 12; v++) begin
      logic [63:0] e;
      int k;
      e = VEC[v];
      k = int'(e[54:46]);
      mode_single_ring = e[32];
      timer_en         = e[33];
      drive_frame(int'(e[15:0]), int'(e[31:16]));
      wait_done(lat);
      check(lat == k + 3, "R5", lat, k + 3);
      check(res_reject == e[34], "R6", res_reject, e[34]);
      check(res_queue == e[40:35], "R4", res_queue, e[40:35]);
      check(res_ring == e[43:41], "R7", res_ring, e[43:41]);
      check(res_evt_filer == e[44] && res_evt_timer == e[45], "R8",
            {res_evt_filer, res_evt_timer}, {e[44], e[45]});
      @(negedge clk);
      check(res_evt_filer == 0 && res_evt_timer == 0 && res_done == 0, "R8",
            {res_done, res_evt_filer, res_evt_timer}, 0);
    end

    // R11 writes and frames ignored while busy
    mode_single_ring = 1'b0;
    timer_en = 1'b0;
    base = n_done;
    drive_frame('h0070, 'h0005);
    check(cfg_busy == 1, "R11", cfg_busy, 1);
    put_entry(0, rw(0, 0, 0, 1, 0, 0), 'h0100);
    drive_frame('h0100, 'h0000);
    wait_done(lat);
    check(res_queue == 0 && res_reject == 0, "R10", {res_reject, res_queue}, 0);
    repeat (30) @(negedge clk);
    check(n_done == base + 1, "R11", n_done - base, 1);
    read_ctl(0, rd);
    check(rd == 32'h0000_0045, "R11", rd, 32'h0000_0045);
    drive_frame('h0100, 'h0000);
    wait_done(lat);
    check(res_queue == 5 && res_reject == 0 && lat == 3, "R11",
          {res_reject, res_queue}, 5);

    $display("%0d/%0d checks passed", passes, passes + fails);
    $finish;
  end
endmodule